// File: doc/BRIEF.md
# Dual Auto-Reload Down-Counter Timer

This block holds two independent 16-bit timer channels that share one free-running prescaler. The prescaler divides the system clock by a fixed ratio (20 by default), so both channels step on the same clock edges. Each channel counts down from a value written by software. When it steps from zero, it reloads from its own reload register and sets a zero flag. That flag can raise an interrupt line for the channel.

Channel 1 can also drive a waveform pin. The pin changes level each time channel 1 reloads, so a periodic square wave appears at a software-chosen rate. Software reaches the block through a simple register port: a one-cycle write strobe, a one-cycle read strobe, a 3-bit address, and a registered read-data bus that is valid one cycle after the read strobe.

Top module: `prt_pair`

## Requirements
- R1: After synchronous reset, the count, reload, control and status registers all read as 0, and `irq` and `wave_out` are low.
- R2: The prescaler runs freely from reset. It produces one step every DIV clock cycles, and it is shared by both channels, so a count changes only on a step cycle or on a software write.
- R3: A channel whose run bit is set, and whose count is nonzero, decreases its count by exactly one on each prescaler step. With DIV = 20, a window of 200 cycles contains exactly 10 steps.
- R4: A running channel whose count is 0 loads its reload value at the next step and sets its zero flag. Status register (address 5) bit 0 holds the channel 0 flag and bit 1 holds the channel 1 flag.
- R5: A channel whose run bit is clear holds its count.
- R6: A write to a count register (address 0 for channel 0, address 2 for channel 1) takes effect on the next cycle and overrides a step on the same cycle. A read returns, on `rdata` one cycle after `rd_en`, the register value as it stood when the read was sampled.
- R7: A zero flag clears only when software reads the status register while the flag is set, and later reads that channel's count register. A count read without that earlier status read leaves the flag set. A flag being set on the same cycle wins over a clear.
- R8: `irq[i]` is high one cycle after channel i's zero flag and its interrupt-enable bit are both high. The control register is at address 4: bit 0 is run for channel 0, bit 1 is run for channel 1, bit 2 is interrupt enable for channel 0, bit 3 is interrupt enable for channel 1, and bit 4 is wave enable.
- R9: While wave enable is set, `wave_out` toggles on every channel 1 reload. While wave enable is clear, `wave_out` holds its last level.
- R10: Reload registers are at address 1 (channel 0) and address 3 (channel 1) and read back as written. Addresses 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | W | Write data |
| rdata | output | W | Registered read data, valid one cycle after rd_en |
| irq | output | 2 | Per-channel interrupt request |
| wave_out | output | 1 | Channel 1 waveform output |

## Verification
The assertions assume that `wr_en` and `rd_en` are never both high in a cycle, and that `addr` holds only the eight decoded values. They also assume that reset is held for at least one clock before any access. The stimulus drives every access as a single-cycle strobe from a task that raises exactly one strobe at a time. That task leaves the bus idle between accesses. Writes to the control register are used to stop a channel before its flag is inspected, so that a step cannot race the flag-clear sequence.

// File: rtl/prt_pkg.sv
package prt_pkg;
  localparam int unsigned NCH   = 2;
  localparam int unsigned CTRLW = 5;

  typedef enum logic [2:0] {
    A_CNT0 = 3'd0,
    A_RLD0 = 3'd1,
    A_CNT1 = 3'd2,
    A_RLD1 = 3'd3,
    A_CTRL = 3'd4,
    A_STAT = 3'd5
  } prt_addr_e;

  localparam int unsigned B_RUN0 = 0;
  localparam int unsigned B_RUN1 = 1;
  localparam int unsigned B_IE0  = 2;
  localparam int unsigned B_IE1  = 3;
  localparam int unsigned B_WAVE = 4;
endpackage

// File: rtl/prt_prescaler.sv
module prt_prescaler #(
  parameter int unsigned DIV = 20
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst)              phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                  phase <= phase + 1'b1;
  end

  assign tick = (phase == LAST);
endmodule

// File: rtl/prt_channel.sv
module prt_channel #(
  parameter int unsigned W        = 16,
  parameter bit          HAS_WAVE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         run,
  input  logic         wr_cnt,
  input  logic         wr_rld,
  input  logic [W-1:0] wdata,
  input  logic         clr_flag,
  input  logic         wave_en,
  output logic [W-1:0] count,
  output logic [W-1:0] reload,
  output logic         flag,
  output logic         wave
);
  logic step;
  logic zero_hit;

  assign step     = tick & run & ~wr_cnt;
  assign zero_hit = step & (count == '0);

  always_ff @(posedge clk) begin
    if (rst)           count <= '0;
    else if (wr_cnt)   count <= wdata;
    else if (zero_hit) count <= reload;
    else if (step)     count <= count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)         reload <= '0;
    else if (wr_rld) reload <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (zero_hit) flag <= 1'b1;
    else if (clr_flag) flag <= 1'b0;
  end

  generate
    if (HAS_WAVE) begin : g_wave
      always_ff @(posedge clk) begin
        if (rst)                      wave <= 1'b0;
        else if (zero_hit && wave_en) wave <= ~wave;
      end
    end else begin : g_nowave
      logic unused_wave_en;
      assign unused_wave_en = wave_en;
      assign wave = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/prt_pair.sv
module prt_pair #(
  parameter int unsigned W   = 16,
  parameter int unsigned DIV = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic [1:0]   irq,
  output logic         wave_out
);
  import prt_pkg::*;

  logic                  tick;
  logic [CTRLW-1:0]      ctrl_q;
  logic [NCH-1:0]        wr_cnt, wr_rld, rd_cnt, clr, arm, flag_w, wave_w;
  logic [NCH-1:0][W-1:0] cnt_w, rld_w;
  logic                  rd_stat;
  logic                  unused_wave0;

  prt_prescaler #(.DIV(DIV)) u_pre (.clk(clk), .rst(rst), .tick(tick));

  assign rd_stat = rd_en && (addr == A_STAT);

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign wr_cnt[i] = wr_en && (addr == 3'(2*i));
      assign wr_rld[i] = wr_en && (addr == 3'(2*i+1));
      assign rd_cnt[i] = rd_en && (addr == 3'(2*i));
      assign clr[i]    = rd_cnt[i] && arm[i];

      always_ff @(posedge clk) begin
        if (rst)            arm[i] <= 1'b0;
        else if (rd_stat)   arm[i] <= flag_w[i];
        else if (rd_cnt[i]) arm[i] <= 1'b0;
      end

      prt_channel #(.W(W), .HAS_WAVE(i == 1)) u_ch (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .run     (ctrl_q[B_RUN0+i]),
        .wr_cnt  (wr_cnt[i]),
        .wr_rld  (wr_rld[i]),
        .wdata   (wdata),
        .clr_flag(clr[i]),
        .wave_en (ctrl_q[B_WAVE]),
        .count   (cnt_w[i]),
        .reload  (rld_w[i]),
        .flag    (flag_w[i]),
        .wave    (wave_w[i])
      );
    end
  endgenerate

  assign wave_out     = wave_w[1];
  assign unused_wave0 = wave_w[0];

  always_ff @(posedge clk) begin
    if (rst)                           ctrl_q <= '0;
    else if (wr_en && addr == A_CTRL)  ctrl_q <= wdata[CTRLW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        A_CNT0:  rdata <= cnt_w[0];
        A_RLD0:  rdata <= rld_w[0];
        A_CNT1:  rdata <= cnt_w[1];
        A_RLD1:  rdata <= rld_w[1];
        A_CTRL:  rdata <= W'(ctrl_q);
        A_STAT:  rdata <= W'(flag_w);
        default: rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= '0;
    else     irq <= flag_w & ctrl_q[B_IE1:B_IE0];
  end
endmodule

// File: rtl/prt_pair_chk.sv
module prt_pair_chk #(
  parameter int unsigned W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                tick,
  input logic [1:0]          run,
  input logic [1:0]          wr_cnt,
  input logic [1:0]          ie,
  input logic [1:0]          flag,
  input logic [1:0]          irq,
  input logic                wave_en,
  input logic                wave,
  input logic [1:0][W-1:0]   cnt
);
  generate
    for (genvar i = 0; i < 2; i++) begin : g_a
      // R2: no step, no write -> count unchanged
      a_r2_step_only: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_cnt[i]) |=> $stable(cnt[i]));
      // R3: running nonzero count drops by one
      a_r3_decrement: assert property (@(posedge clk) disable iff (rst)
        (tick && run[i] && !wr_cnt[i] && cnt[i] != '0) |=> (cnt[i] == $past(cnt[i]) - 1'b1));
      // R4: step at zero sets the flag
      a_r4_flag_set: assert property (@(posedge clk) disable iff (rst)
        (tick && run[i] && !wr_cnt[i] && cnt[i] == '0) |=> flag[i]);
      // R5: stopped channel holds
      a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!run[i] && !wr_cnt[i]) |=> $stable(cnt[i]));
      // R8: interrupt follows flag and enable
      a_r8_irq: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq[i] == $past(flag[i] && ie[i])));
    end
  endgenerate

  // R9: wave holds while disabled
  a_r9_wave_hold: assert property (@(posedge clk) disable iff (rst)
    !wave_en |=> $stable(wave));
endmodule

bind prt_pair prt_pair_chk #(.W(W)) i_chk (
  .clk    (clk),
  .rst    (rst),
  .tick   (tick),
  .run    (ctrl_q[1:0]),
  .wr_cnt (wr_cnt),
  .ie     (ctrl_q[3:2]),
  .flag   (flag_w),
  .irq    (irq),
  .wave_en(ctrl_q[4]),
  .wave   (wave_out),
  .cnt    (cnt_w)
);

// File: tb/test_prt_pair.sv
`timescale 1ns/1ps
module test_prt_pair;
  localparam int W   = 16;
  localparam int DIV = 20;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]   addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic [1:0]   irq;
  logic         wave_out;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prt_pair #(.W(W), .DIV(DIV)) i_prt_pair (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .wave_out(wave_out));

  // behavioural reference
  int m_pre;
  int m_cnt [2];
  int m_rld [2];
  int m_flag[2];
  int m_arm [2];
  int m_ctrl, m_rdata, m_irq, m_wave;

  always @(posedge clk) begin
    if (rst) begin
      m_pre = 0; m_ctrl = 0; m_rdata = 0; m_irq = 0; m_wave = 0;
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = 0; m_rld[c] = 0; m_flag[c] = 0; m_arm[c] = 0;
      end
    end else begin
      bit stepping;
      int o_cnt[2], o_flag[2], o_ctrl, a;
      a = int'(addr);
      stepping = (m_pre == DIV - 1);
      m_pre = stepping ? 0 : m_pre + 1;
      o_ctrl = m_ctrl;
      for (int c = 0; c < 2; c++) begin o_cnt[c] = m_cnt[c]; o_flag[c] = m_flag[c]; end
      if (rd_en) begin
        case (a)
          0: m_rdata = o_cnt[0];
          1: m_rdata = m_rld[0];
          2: m_rdata = o_cnt[1];
          3: m_rdata = m_rld[1];
          4: m_rdata = o_ctrl;
          5: m_rdata = o_flag[0] + 2 * o_flag[1];
          default: m_rdata = 0;
        endcase
      end
      m_irq = (o_flag[0] & ((o_ctrl >> 2) & 1)) + 2 * (o_flag[1] & ((o_ctrl >> 3) & 1));
      for (int c = 0; c < 2; c++) begin
        bit hit;
        hit = 0;
        if (wr_en && a == 2 * c) m_cnt[c] = int'(wdata);
        else if (stepping && ((o_ctrl >> c) & 1) == 1) begin
          if (o_cnt[c] == 0) begin
            m_cnt[c] = m_rld[c]; hit = 1;
            if (c == 1 && ((o_ctrl >> 4) & 1) == 1) m_wave = 1 - m_wave;
          end else m_cnt[c] = o_cnt[c] - 1;
        end
        if (hit) m_flag[c] = 1;
        else if (rd_en && a == 2 * c && m_arm[c] == 1) m_flag[c] = 0;
        if (rd_en && a == 5) m_arm[c] = o_flag[c];
        else if (rd_en && a == 2 * c) m_arm[c] = 0;
        if (wr_en && a == 2 * c + 1) m_rld[c] = int'(wdata);
      end
      if (wr_en && a == 4) m_ctrl = int'(wdata) & 31;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (int'(rdata) != m_rdata) begin errors++; $display("FAIL R6 rdata act=%0h exp=%0h", rdata, m_rdata); end
      checks++;
      if (int'(irq) != m_irq) begin errors++; $display("FAIL R8 irq act=%0d exp=%0d", irq, m_irq); end
      checks++;
      if (int'(wave_out) != m_wave) begin errors++; $display("FAIL R9 wave act=%0d exp=%0d", wave_out, m_wave); end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin errors++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; addr = 3'(a); wdata = W'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); rd_en = 1; addr = 3'(a);
    @(negedge clk); rd_en = 0; v = int'(rdata);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R2 watchdog act=timeout exp=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, t0, toggles, last;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 irq", int'(irq), 0); chk("R1 wave", int'(wave_out), 0);
    rd(0, v); chk("R1 cnt0", v, 0);
    rd(3, v); chk("R1 rld1", v, 0);
    rd(4, v); chk("R1 ctrl", v, 0);
    rd(5, v); chk("R1 stat", v, 0);
    // R6 immediate write, R5 hold while stopped
    wr(0, 16'h1234); rd(0, v); chk("R6 cnt0 write", v, 16'h1234);
    repeat (100) @(negedge clk);
    rd(0, v); chk("R5 cnt0 hold", v, 16'h1234);
    // R10 reload readback and unused addresses
    wr(1, 16'hBEEF); rd(1, v); chk("R10 rld0", v, 16'hBEEF);
    wr(3, 16'h0F0F); rd(3, v); chk("R10 rld1", v, 16'h0F0F);
    rd(6, v); chk("R10 addr6", v, 0);
    rd(7, v); chk("R10 addr7", v, 0);
    // R4 reload and flag, R8 irq
    wr(1, 2); wr(0, 2); wr(4, 5'b00101);
    repeat (90) @(negedge clk);
    wr(4, 5'b00100);
    @(negedge clk);
    chk("R8 irq0 set", int'(irq), 1);
    // R7 count read without status read keeps flag
    rd(0, v); rd(5, v); chk("R7 flag kept", v, 1);
    chk("R4 flag", v & 1, 1);
    rd(0, v); rd(5, v); chk("R7 flag cleared", v, 0);
    @(negedge clk);
    chk("R8 irq0 clear", int'(irq), 0);
    // R3 exact step count: 200 cycles hold 10 steps
    wr(1, 100); wr(4, 5'b00001); wr(0, 100);
    repeat (200) @(negedge clk);
    rd(0, v); chk("R3 ten steps", v, 90);
    // R9 wave toggling on channel 1
    wr(4, 0); wr(3, 1); wr(2, 1); wr(4, 5'b10010);
    repeat (100) @(negedge clk);
    toggles = 0; last = int'(wave_out);
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (int'(wave_out) != last) toggles++;
      last = int'(wave_out);
    end
    chk("R9 toggles", toggles, 10);
    wr(4, 5'b00010);
    t0 = int'(wave_out);
    repeat (200) @(negedge clk);
    chk("R9 wave hold", int'(wave_out), t0);
    rd(5, v); chk("R4 flag1", (v >> 1) & 1, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule